// File: doc/BRIEF.md
# Sync Phase Error Threshold Monitor

This block runs on a fast clock and measures how many of its cycles separate an input frame-sync event from the next output frame-sync event. From that count it subtracts a programmed target skew. It reports the signed result as a 9-bit error. When the error leaves a symmetric window around zero, it raises an alarm.

A single-cycle strobe on `sync_in_stb` starts a measurement. A strobe on `sync_out_stb` ends it. One cycle later the error register and the alarm flag both take their new values. They then hold until the next completed measurement. The window half-width comes from a 3-bit code through a fixed, non-uniform lookup.

The block only measures and flags. Acting on the alarm, for example by realigning, is left to the surrounding logic.

Top module: `sync_skew_monitor`

## Requirements
- R1: While reset is asserted, and after its release until the first completed measurement, `skew_err` reads 0 and `skew_alarm` reads 0.
- R2: If `sync_in_stb` is sampled high at clock edge k and `sync_out_stb` is next sampled high at edge k+d (d >= 1), the measured skew is d. After edge k+d+1, `skew_err` equals d minus `skew_target`, and it is unchanged after edge k+d.
- R3: An error above +255 is reported as +255 (9-bit two's complement 0x0FF).
- R4: An error below -256 is reported as -256 (9-bit two's complement 0x100). This holds down to the largest target of 131071.
- R5: The window half-width T for `thr_sel` codes 0 to 7 is, in order: 4, 8, 16, 32, 48, 64, 96, 128 cycles.
- R6: `skew_alarm` is set by a measurement whose saturated error E satisfies E > T or E < -T. An error of exactly +T or -T does not set it.
- R7: A measurement whose error lies within [-T, +T] clears `skew_alarm`. Between measurements the alarm keeps its value.
- R8: A `sync_in_stb` that arrives while a measurement is open restarts the count from that newer strobe.
- R9: A `sync_out_stb` with no open measurement is ignored: `skew_err` and `skew_alarm` keep their values.
- R10: The skew count saturates at 2^CNT_W-1 cycles and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in_stb | input | 1 | One-cycle strobe marking an input sync edge |
| sync_out_stb | input | 1 | One-cycle strobe marking an output sync edge |
| skew_target | input | 17 | Desired skew in clock cycles, unsigned |
| thr_sel | input | 3 | Alarm window code |
| skew_err | output | 9 | Saturated signed skew error, two's complement |
| skew_alarm | output | 1 | Set while the last error lay outside the window |

## Verification
The output strobe is captured at edge k+d, and `skew_err` and `skew_alarm` both change at edge k+d+1. So each directed task samples on the falling edge after k+d+1. The basic case also samples one cycle earlier to confirm the old value still stands. For ignored strobes and for hold behaviour, the bench waits several cycles past the point where an update would have landed, then compares against the previous result. Inputs change only on falling edges, so every rising edge sees settled strobes, target and code.

// File: rtl/sync_skew_pkg.sv
package sync_skew_pkg;

  localparam int unsigned THR_CODE_W = 3;
  localparam int unsigned THR_VAL_W  = 8;

  // Non-uniform window half-width table, indexed by the 3-bit code.
  function automatic logic [THR_VAL_W-1:0] thr_lookup(input logic [THR_CODE_W-1:0] code);
    logic [THR_VAL_W-1:0] t;
    case (code)
      3'd0:    t = 8'd4;
      3'd1:    t = 8'd8;
      3'd2:    t = 8'd16;
      3'd3:    t = 8'd32;
      3'd4:    t = 8'd48;
      3'd5:    t = 8'd64;
      3'd6:    t = 8'd96;
      default: t = 8'd128;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sync_skew_rst_sync.sv
module sync_skew_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sync_skew_counter.sv
module sync_skew_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_edge,
  input  logic             out_edge,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld,
  output logic             armed
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             vld_q, vld_d;
  logic             cnt_en, capture;

  // Elapsed cycles including the current edge, held at the ceiling.
  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  always_comb begin
    capture = out_edge && armed_q;
    cnt_en  = in_edge || armed_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (in_edge) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else begin
      if (armed_q) cnt_d = cnt_inc;
      if (out_edge) armed_d = 1'b0;
    end
    vld_d  = capture;
    meas_d = capture ? cnt_inc : meas_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      meas_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      armed_q <= armed_d;
      if (capture) meas_q <= meas_d;
      vld_q   <= vld_d;
    end
  end

  assign meas     = meas_q;
  assign meas_vld = vld_q;
  assign armed    = armed_q;

endmodule

// File: rtl/sync_skew_error.sv
module sync_skew_error #(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned TGT_W = 17,
  parameter int unsigned ERR_W = 9
) (
  input  logic [CNT_W-1:0] meas,
  input  logic [TGT_W-1:0] target,
  output logic [ERR_W-1:0] err_sat
);

  localparam int unsigned OP_W  = (CNT_W > TGT_W) ? CNT_W : TGT_W;
  localparam int unsigned DIF_W = OP_W + 2;
  localparam logic signed [DIF_W-1:0] ERR_MAX = DIF_W'((2 ** (ERR_W - 1)) - 1);
  localparam logic signed [DIF_W-1:0] ERR_MIN = -DIF_W'(2 ** (ERR_W - 1));

  logic signed [DIF_W-1:0] meas_ext, tgt_ext, diff;

  always_comb begin
    meas_ext = signed'(DIF_W'(meas));
    tgt_ext  = signed'(DIF_W'(target));
    diff     = meas_ext - tgt_ext;
    if (diff > ERR_MAX)      err_sat = ERR_MAX[ERR_W-1:0];
    else if (diff < ERR_MIN) err_sat = ERR_MIN[ERR_W-1:0];
    else                     err_sat = diff[ERR_W-1:0];
  end

endmodule

// File: rtl/sync_skew_window.sv
module sync_skew_window
  import sync_skew_pkg::*;
#(
  parameter int unsigned ERR_W = 9
) (
  input  logic [ERR_W-1:0]      err,
  input  logic [THR_CODE_W-1:0] code,
  output logic                  outside
);

  localparam int unsigned CMP_W = ((ERR_W > THR_VAL_W) ? ERR_W : THR_VAL_W) + 2;

  logic signed [CMP_W-1:0] err_ext, thr_pos, thr_neg;

  always_comb begin
    err_ext = CMP_W'(signed'(err));
    thr_pos = signed'(CMP_W'(thr_lookup(code)));
    thr_neg = -thr_pos;
    outside = (err_ext > thr_pos) || (err_ext < thr_neg);
  end

endmodule

// File: rtl/sync_skew_monitor.sv
module sync_skew_monitor
  import sync_skew_pkg::*;
#(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned TGT_W = 17,
  parameter int unsigned ERR_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_in_stb,
  input  logic                  sync_out_stb,
  input  logic [TGT_W-1:0]      skew_target,
  input  logic [THR_CODE_W-1:0] thr_sel,
  output logic [ERR_W-1:0]      skew_err,
  output logic                  skew_alarm
);

  logic             rst_n_s;
  logic [CNT_W-1:0] meas;
  logic             meas_vld;
  logic             armed;
  logic [ERR_W-1:0] err_nxt;
  logic             out_nxt;
  logic [ERR_W-1:0] err_q, err_d;
  logic             alarm_q, alarm_d;

  sync_skew_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sync_skew_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_edge  (sync_in_stb),
    .out_edge (sync_out_stb),
    .meas     (meas),
    .meas_vld (meas_vld),
    .armed    (armed)
  );

  sync_skew_error #(.CNT_W(CNT_W), .TGT_W(TGT_W), .ERR_W(ERR_W)) u_err (
    .meas    (meas),
    .target  (skew_target),
    .err_sat (err_nxt)
  );

  sync_skew_window #(.ERR_W(ERR_W)) u_win (
    .err     (err_nxt),
    .code    (thr_sel),
    .outside (out_nxt)
  );

  always_comb begin
    err_d   = err_nxt;
    alarm_d = out_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_q   <= '0;
      alarm_q <= 1'b0;
    end else if (meas_vld) begin
      err_q   <= err_d;
      alarm_q <= alarm_d;
    end
  end

  assign skew_err   = err_q;
  assign skew_alarm = alarm_q;

endmodule

// File: rtl/sync_skew_chk.sv
module sync_skew_chk #(
  parameter int unsigned ERR_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_edge,
  input logic             out_edge,
  input logic             armed,
  input logic             meas_vld,
  input logic [ERR_W-1:0] err,
  input logic             alarm
);

  // R9
  unarmed_out_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_edge && !armed) |=> !meas_vld);

  // R8
  rearm_on_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_edge |=> armed);

  // R7
  hold_between_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> ($stable(err) && $stable(alarm)));

  // R6
  wide_err_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($signed(err) > 128) || ($signed(err) < -128)) |-> alarm);

  // R7
  narrow_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($signed(err) <= 4) && ($signed(err) >= -4)) |-> !alarm);

endmodule

bind sync_skew_monitor sync_skew_chk #(.ERR_W(ERR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .in_edge  (sync_in_stb),
  .out_edge (sync_out_stb),
  .armed    (armed),
  .meas_vld (meas_vld),
  .err      (skew_err),
  .alarm    (skew_alarm)
);

// File: tb/sim_sync_skew_monitor.sv
`timescale 1ns/1ps
module sim_sync_skew_monitor;

  localparam int CNT_W = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_in_stb;
  logic        sync_out_stb;
  logic [16:0] skew_target;
  logic [2:0]  thr_sel;
  logic [8:0]  skew_err;
  logic        skew_alarm;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sync_skew_monitor #(.CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in_stb  (sync_in_stb),
    .sync_out_stb (sync_out_stb),
    .skew_target  (skew_target),
    .thr_sel      (thr_sel),
    .skew_err     (skew_err),
    .skew_alarm   (skew_alarm)
  );

  function automatic int thr_of(input int code);
    case (code)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 48;  5: return 64;  6: return 96;  default: return 128;
    endcase
  endfunction

  function automatic int clamp(input int v);
    if (v > 255)  return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int err_now();
    return int'($signed(skew_err));
  endfunction

  // Input strobe at edge k, output strobe at edge k+d; returns after edge k+d+1.
  task automatic measure(input int d, input int tgt, input int code,
                         input bit early_chk, input int prev_err, input string req);
    skew_target = 17'(tgt);
    thr_sel     = 3'(code);
    sync_in_stb = 1'b1;
    @(negedge clk);
    sync_in_stb = 1'b0;
    repeat (d - 1) @(negedge clk);
    sync_out_stb = 1'b1;
    @(negedge clk);
    sync_out_stb = 1'b0;
    if (early_chk) check({req, " not yet updated"}, err_now(), prev_err);
    @(negedge clk);
  endtask

  task automatic expect_result(input string req, input int raw, input int code);
    int e;
    e = clamp(raw);
    check({req, " error"}, err_now(), e);
    check({req, " alarm"}, int'(skew_alarm), int'((e > thr_of(code)) || (e < -thr_of(code))));
  endtask

  task automatic t_reset();
    check("R1 error at reset", err_now(), 0);
    check("R1 alarm at reset", int'(skew_alarm), 0);
  endtask

  task automatic t_basic();
    measure(20, 10, 1, 1'b1, 0, "R2");
    expect_result("R2 d20 t10", 10, 1);
    measure(7, 3, 2, 1'b0, 0, "R2");
    expect_result("R2 d7 t3", 4, 2);
    measure(5, 12, 0, 1'b0, 0, "R2");
    expect_result("R2 negative d5 t12", -7, 0);
  endtask

  task automatic t_clear();
    measure(10, 10, 0, 1'b0, 0, "R7");
    expect_result("R7 in-window clears", 0, 0);
  endtask

  task automatic t_window();
    for (int c = 0; c < 8; c++) begin
      int t;
      t = thr_of(c);
      measure(5 + t, 5, c, 1'b0, 0, "R5");
      check("R5 R6 at +T no alarm", int'(skew_alarm), 0);
      measure(6 + t, 5, c, 1'b0, 0, "R5");
      check("R5 R6 at +T+1 alarm", int'(skew_alarm), 1);
      measure(200 - t, 200, c, 1'b0, 0, "R5");
      check("R5 R6 at -T no alarm", int'(skew_alarm), 0);
      measure(199 - t, 200, c, 1'b0, 0, "R5");
      check("R5 R6 at -T-1 alarm", int'(skew_alarm), 1);
    end
  endtask

  task automatic t_sat();
    measure(400, 0, 7, 1'b0, 0, "R3");
    expect_result("R3 positive saturation", 400, 7);
    measure(3, 100000, 7, 1'b0, 0, "R4");
    expect_result("R4 negative saturation", 3 - 100000, 7);
    measure(2, 131071, 0, 1'b0, 0, "R4");
    expect_result("R4 largest target", 2 - 131071, 0);
  endtask

  task automatic t_restart();
    skew_target = 17'd0;
    thr_sel     = 3'd7;
    sync_in_stb = 1'b1;
    @(negedge clk);
    sync_in_stb = 1'b0;
    repeat (29) @(negedge clk);
    measure(10, 0, 7, 1'b0, 0, "R8");
    expect_result("R8 restart from newer strobe", 10, 7);
  endtask

  task automatic t_ignore();
    int prev_e, prev_a;
    measure(60, 0, 1, 1'b0, 0, "R9");
    prev_e = err_now();
    prev_a = int'(skew_alarm);
    check("R9 setup alarm", prev_a, 1);
    skew_target = 17'd60;
    sync_out_stb = 1'b1;
    @(negedge clk);
    sync_out_stb = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 stray strobe error kept", err_now(), prev_e);
    check("R9 stray strobe alarm kept", int'(skew_alarm), prev_a);
  endtask

  task automatic t_cnt_sat();
    measure(1100, 900, 7, 1'b0, 0, "R10");
    expect_result("R10 count ceiling", (2 ** CNT_W - 1) - 900, 7);
  endtask

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    sync_in_stb  = 1'b0;
    sync_out_stb = 1'b0;
    skew_target  = '0;
    thr_sel      = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_window();
    t_sat();
    t_restart();
    t_ignore();
    t_cnt_sat();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule